// File: doc/BRIEF.md
# Multiplexed Readout Frame Decoder with Channel Reordering

This block sits behind the ADC of a multiplexed analog front-end chip. The chip drives one analog line. Each analog level on that line stays for two ADC sample periods, so the block averages each pair of samples into one value. Between triggers the line carries short periodic idle ticks. After a trigger the line carries a frame made of four digital header levels, eight digital address levels and then 128 analog channel values. The channels arrive in an interleaved order that a fixed multiplexer tree produces.

The block classifies each level as a logic one or zero against a programmable threshold. A polarity input sets the direction of that comparison. The block refuses to start a frame on a lone idle tick. It captures the header and the pipeline address. It stores the 128 averaged channel values in one half of a ping-pong buffer while the other half is read out in natural channel order. Each read-out word carries first and last flags, and the header and address of its frame appear beside it. A frame that is cut short is dropped and reported with a one-cycle error pulse.

Top module: `frame_reorder`

## Requirements
- R1: After reset, `chanValid`, `chanFirst`, `chanLast` and `frameErr` are low.
- R2: An idle tick, one high level (two high samples) followed by low levels, never produces output words or a frame error.
- R3: A frame starts only when its first two header levels both read high. `frameHdr` holds all four header bits, with the first bit received in bit 3.
- R4: The eight address levels are shifted in MSB first. `frameAddr` shows the frame's address from its first output word and holds it steady for the whole burst.
- R5: Every stored value is the floor of the mean of its two samples, floor((a+b)/2).
- R6: The k-th output word of a frame (k = 0..127) is the value that arrived at data position 32·(k mod 4) + 8·((k div 4) mod 4) + (k div 16).
- R7: Each frame is read out as 128 consecutive `chanValid` cycles. `chanFirst` is set on word 0 only and `chanLast` on word 127 only.
- R8: With `invertPol` = 0 a level is high when it is strictly above `logicThresh`. With `invertPol` = 1 it is high when it is strictly below `logicThresh`.
- R9: If `sampleValid` drops after a frame's start has been confirmed (both leading header levels high), `frameErr` pulses for exactly one cycle and the partial frame gives no output. The next frame is decoded normally.
- R10: Frames sent back to back with no idle gap are each read out in full, in the order they arrived.
- R11: A level exactly equal to `logicThresh` reads as low. This applies both to the raw sample that could start a frame and to an averaged header level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new ADC sample is present on `sampleIn` |
| sampleIn | input | SAMPLE_W | ADC sample |
| logicThresh | input | SAMPLE_W | Threshold for reading digital levels |
| invertPol | input | 1 | 1 = a high level lies below the threshold |
| chanValid | output | 1 | Output word valid |
| chanData | output | SAMPLE_W | Channel value, in natural channel order |
| chanFirst | output | 1 | Word is channel 0 |
| chanLast | output | 1 | Word is channel 127 |
| frameAddr | output | 8 | Pipeline address of the frame being read out |
| frameHdr | output | 4 | Header bits of the frame being read out |
| frameErr | output | 1 | One-cycle pulse on a truncated frame |

## Verification
The decoder is driven with repeated lone idle ticks, a frame whose second header level is low, and levels equal to the threshold. Together these show whether start detection needs two confirming high levels and uses a strict comparison. Frames carry distinct pseudo-random data with unequal sample pairs, which separates correct pair averaging and the interleave mapping from off-by-one pairing or a swapped bit field. Inverted polarity, a cut-short frame followed by a good one, and three frames sent back to back check the comparator direction, the discard path, and ping-pong bank switching.

// File: rtl/frame_reorder_pkg.sv
`timescale 1ns/1ps
package frame_reorder_pkg;
  localparam int CH_COUNT   = 128;
  localparam int CH_IDX_W   = $clog2(CH_COUNT);
  localparam int HDR_W      = 4;
  localparam int ADDR_W     = 8;
  localparam int START_BITS = 2;

  typedef struct packed {
    logic                holdFirst;
    logic                shiftHdr;
    logic                shiftAddr;
    logic                writeData;
    logic                wrBank;
    logic [CH_IDX_W-1:0] wrIdx;
    logic                commit;
    logic                rdEn;
    logic                rdBank;
    logic [CH_IDX_W-1:0] rdIdx;
  } strobe_t;

  // natural channel -> arrival slot of the 4x4x8 multiplexer tree
  function automatic logic [CH_IDX_W-1:0] muxSlot(input logic [CH_IDX_W-1:0] ch);
    return {ch[1:0], ch[3:2], ch[6:4]};
  endfunction
endpackage

// File: rtl/frame_ctrl.sv
`timescale 1ns/1ps
module frame_ctrl
  import frame_reorder_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleValid,
  input  logic    rawHigh,
  input  logic    bitHigh,
  output strobe_t st,
  output logic    frameErr
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_ADDR, S_DATA} phase_t;

  localparam logic [CH_IDX_W-1:0] LAST_CH   = CH_IDX_W'(CH_COUNT - 1);
  localparam logic [CH_IDX_W-1:0] HDR_LAST  = CH_IDX_W'(HDR_W - 1);
  localparam logic [CH_IDX_W-1:0] ADDR_LAST = CH_IDX_W'(ADDR_W - 1);
  localparam logic [CH_IDX_W-1:0] START_N   = CH_IDX_W'(START_BITS);

  phase_t              phase;
  logic [CH_IDX_W-1:0] idx;
  logic                pairPh;
  logic                wrBank;
  logic                rdBank;
  logic                rdActive;
  logic [CH_IDX_W-1:0] rdCnt;
  logic [1:0]          bankFull;
  logic                valStep;
  logic                committed;

  always_comb begin
    valStep   = sampleValid && pairPh && (phase != S_IDLE);
    committed = ((phase == S_HDR) && (idx >= START_N)) ||
                (phase == S_ADDR) || (phase == S_DATA);
    st           = '0;
    st.holdFirst = sampleValid && (((phase == S_IDLE) && rawHigh) ||
                                   ((phase != S_IDLE) && !pairPh));
    st.shiftHdr  = valStep && (phase == S_HDR);
    st.shiftAddr = valStep && (phase == S_ADDR);
    st.writeData = valStep && (phase == S_DATA);
    st.wrBank    = wrBank;
    st.wrIdx     = idx;
    st.commit    = st.writeData && (idx == LAST_CH);
    st.rdEn      = rdActive;
    st.rdBank    = rdBank;
    st.rdIdx     = rdCnt;
  end

  // capture sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= S_IDLE;
      idx      <= '0;
      pairPh   <= 1'b0;
      frameErr <= 1'b0;
      wrBank   <= 1'b0;
    end else begin
      frameErr <= 1'b0;
      if (phase == S_IDLE) begin
        if (sampleValid && rawHigh) begin
          phase  <= S_HDR;
          idx    <= '0;
          pairPh <= 1'b1;
        end
      end else if (!sampleValid) begin
        frameErr <= committed;
        phase    <= S_IDLE;
      end else if (!pairPh) begin
        pairPh <= 1'b1;
      end else begin
        pairPh <= 1'b0;
        unique case (phase)
          S_HDR: begin
            if ((idx < START_N) && !bitHigh) phase <= S_IDLE;
            else if (idx == HDR_LAST) begin
              phase <= S_ADDR;
              idx   <= '0;
            end else idx <= idx + 1'b1;
          end
          S_ADDR: begin
            if (idx == ADDR_LAST) begin
              phase <= S_DATA;
              idx   <= '0;
            end else idx <= idx + 1'b1;
          end
          S_DATA: begin
            if (idx == LAST_CH) begin
              phase  <= S_IDLE;
              idx    <= '0;
              wrBank <= ~wrBank;
            end else idx <= idx + 1'b1;
          end
          default: phase <= S_IDLE;
        endcase
      end
    end
  end

  // ping-pong bank ownership and natural-order readout
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankFull <= '0;
      rdBank   <= 1'b0;
      rdActive <= 1'b0;
      rdCnt    <= '0;
    end else begin
      if (rdActive) begin
        if (rdCnt == LAST_CH) begin
          rdActive         <= 1'b0;
          bankFull[rdBank] <= 1'b0;
          rdBank           <= ~rdBank;
        end
        rdCnt <= rdCnt + 1'b1;
      end else if (bankFull[rdBank]) begin
        rdActive <= 1'b1;
        rdCnt    <= '0;
      end
      if (st.commit) bankFull[wrBank] <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_dpath.sv
`timescale 1ns/1ps
module frame_dpath
  import frame_reorder_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] logicThresh,
  input  logic                invertPol,
  input  strobe_t             st,
  output logic                rawHigh,
  output logic                bitHigh,
  output logic                chanValid,
  output logic [SAMPLE_W-1:0] chanData,
  output logic                chanFirst,
  output logic                chanLast,
  output logic [ADDR_W-1:0]   frameAddr,
  output logic [HDR_W-1:0]    frameHdr
);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(CH_COUNT - 1);

  logic [SAMPLE_W-1:0] firstSmp;
  logic [SAMPLE_W:0]   pairSum;
  logic [SAMPLE_W-1:0] pairAvg;
  logic [HDR_W-1:0]    hdrSh;
  logic [ADDR_W-1:0]   addrSh;
  logic [HDR_W-1:0]    metaHdr  [2];
  logic [ADDR_W-1:0]   metaAddr [2];
  logic [SAMPLE_W-1:0] bankMem  [2][CH_COUNT];

  function automatic logic isHigh(input logic [SAMPLE_W-1:0] v,
                                  input logic [SAMPLE_W-1:0] thr,
                                  input logic neg);
    return neg ? (v < thr) : (v > thr);
  endfunction

  always_comb begin
    pairSum = {1'b0, firstSmp} + {1'b0, sampleIn};
    pairAvg = pairSum[SAMPLE_W:1];
    rawHigh = isHigh(sampleIn, logicThresh, invertPol);
    bitHigh = isHigh(pairAvg, logicThresh, invertPol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstSmp <= '0;
      hdrSh    <= '0;
      addrSh   <= '0;
    end else begin
      if (st.holdFirst) firstSmp <= sampleIn;
      if (st.shiftHdr)  hdrSh    <= {hdrSh[HDR_W-2:0], bitHigh};
      if (st.shiftAddr) addrSh   <= {addrSh[ADDR_W-2:0], bitHigh};
    end
  end

  always_ff @(posedge clk) begin
    if (st.writeData) bankMem[st.wrBank][st.wrIdx] <= pairAvg;
    if (st.commit) begin
      metaHdr[st.wrBank]  <= hdrSh;
      metaAddr[st.wrBank] <= addrSh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanValid <= 1'b0;
      chanFirst <= 1'b0;
      chanLast  <= 1'b0;
      chanData  <= '0;
      frameAddr <= '0;
      frameHdr  <= '0;
    end else begin
      chanValid <= st.rdEn;
      chanFirst <= st.rdEn && (st.rdIdx == '0);
      chanLast  <= st.rdEn && (st.rdIdx == LAST_CH);
      if (st.rdEn) begin
        chanData  <= bankMem[st.rdBank][muxSlot(st.rdIdx)];
        frameAddr <= metaAddr[st.rdBank];
        frameHdr  <= metaHdr[st.rdBank];
      end
    end
  end
endmodule

// File: rtl/frame_reorder.sv
`timescale 1ns/1ps
module frame_reorder
  import frame_reorder_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] logicThresh,
  input  logic                invertPol,
  output logic                chanValid,
  output logic [SAMPLE_W-1:0] chanData,
  output logic                chanFirst,
  output logic                chanLast,
  output logic [ADDR_W-1:0]   frameAddr,
  output logic [HDR_W-1:0]    frameHdr,
  output logic                frameErr
);
  strobe_t st;
  logic    rawHigh;
  logic    bitHigh;

  frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .rawHigh(rawHigh), .bitHigh(bitHigh), .st(st), .frameErr(frameErr)
  );

  frame_dpath #(.SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .logicThresh(logicThresh),
    .invertPol(invertPol), .st(st), .rawHigh(rawHigh), .bitHigh(bitHigh),
    .chanValid(chanValid), .chanData(chanData), .chanFirst(chanFirst),
    .chanLast(chanLast), .frameAddr(frameAddr), .frameHdr(frameHdr)
  );
endmodule

// File: rtl/frame_reorder_chk.sv
`timescale 1ns/1ps
module frame_reorder_chk
  import frame_reorder_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              chanValid,
  input logic              chanFirst,
  input logic              chanLast,
  input logic [ADDR_W-1:0] frameAddr,
  input logic              frameErr
);
  // R7
  first_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanFirst |-> chanValid);
  // R7
  last_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanLast |-> chanValid);
  // R7
  burst_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanValid && !chanLast) |=> chanValid);
  // R7
  first_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanFirst |=> !chanFirst);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanValid && !chanFirst) |-> $stable(frameAddr));
endmodule

bind frame_reorder frame_reorder_chk u_chk (
  .clk(clk), .rstN(rstN), .chanValid(chanValid), .chanFirst(chanFirst),
  .chanLast(chanLast), .frameAddr(frameAddr), .frameErr(frameErr)
);

// File: tb/frame_reorder_bench.sv
`timescale 1ns/1ps
module frame_reorder_bench;
  localparam int SW  = 12;
  localparam int THR = 2048;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic [SW-1:0] logicThresh = SW'(THR);
  logic          invertPol = 1'b0;
  logic          chanValid, chanFirst, chanLast, frameErr;
  logic [SW-1:0] chanData;
  logic [7:0]    frameAddr;
  logic [3:0]    frameHdr;

  always #2 clk = ~clk;

  frame_reorder #(.SAMPLE_W(SW)) u_frame_reorder (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .logicThresh(logicThresh), .invertPol(invertPol), .chanValid(chanValid),
    .chanData(chanData), .chanFirst(chanFirst), .chanLast(chanLast),
    .frameAddr(frameAddr), .frameHdr(frameHdr), .frameErr(frameErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [SW-1:0] capData [16][128];
  logic [7:0]    capAddr [16];
  logic [3:0]    capHdr  [16];
  logic [SW-1:0] expAll  [16][128];
  int frameCount = 0;
  int expFrames = 0;
  int wordIdx = 0;
  int flagBad = 0;
  int errPulses = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (frameErr) errPulses++;
      if (chanValid) begin
        if (wordIdx < 128) capData[frameCount % 16][wordIdx] = chanData;
        if (chanFirst != (wordIdx == 0)) flagBad++;
        if (chanLast != (wordIdx == 127)) flagBad++;
        if (wordIdx == 0) begin
          capHdr[frameCount % 16]  = frameHdr;
          capAddr[frameCount % 16] = frameAddr;
        end
        if (chanLast) begin
          frameCount++;
          wordIdx = 0;
        end else wordIdx++;
      end else if (wordIdx != 0) flagBad++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] hiLvl();
    return invertPol ? SW'(500) : SW'(3500);
  endfunction
  function automatic logic [SW-1:0] loLvl();
    return invertPol ? SW'(3500) : SW'(500);
  endfunction

  task automatic putSample(input logic [SW-1:0] v, input logic vld);
    @(posedge clk); #1;
    sampleValid = vld;
    sampleIn    = v;
  endtask
  task automatic putValue(input logic [SW-1:0] a, input logic [SW-1:0] b);
    putSample(a, 1'b1);
    putSample(b, 1'b1);
  endtask
  task automatic idleLow(input int n);
    for (int i = 0; i < n; i++) putSample(loLvl(), 1'b1);
  endtask
  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // eqTail: last header level sent exactly at the threshold; truncAt < 0: complete frame
  task automatic sendFrame(input logic [1:0] tail, input logic [7:0] addr,
                           input int seed, input bit eqTail, input int truncAt,
                           input int gap);
    putValue(hiLvl(), hiLvl());
    putValue(hiLvl(), hiLvl());
    if (tail[1]) putValue(hiLvl(), hiLvl()); else putValue(loLvl(), loLvl());
    if (eqTail)       putValue(SW'(THR), SW'(THR));
    else if (tail[0]) putValue(hiLvl(), hiLvl());
    else              putValue(loLvl(), loLvl());
    for (int i = 7; i >= 0; i--)
      if (addr[i]) putValue(hiLvl(), hiLvl()); else putValue(loLvl(), loLvl());
    for (int p = 0; p < 128; p++) begin
      int a;
      int b;
      if (p == truncAt) begin
        putSample(loLvl(), 1'b0);
        idleLow(4);
        return;
      end
      a = (seed * 37 + p * 29) % 4000;
      b = a + (p % 5);
      expAll[expFrames % 16][p] = SW'((a + b) / 2);
      putValue(SW'(a), SW'(b));
    end
    expFrames++;
    idleLow(gap);
  endtask

  task automatic checkFrame(input int idx, input logic [3:0] hdr, input logic [7:0] addr);
    int bad = 0;
    int firstBad = -1;
    check(capHdr[idx % 16] == hdr, "R3 header bits", int'(capHdr[idx % 16]), int'(hdr));
    check(capAddr[idx % 16] == addr, "R4 address", int'(capAddr[idx % 16]), int'(addr));
    check(capData[idx % 16][0] == expAll[idx % 16][0], "R5 pair average of channel 0",
          int'(capData[idx % 16][0]), int'(expAll[idx % 16][0]));
    for (int k = 0; k < 128; k++) begin
      int slot = 32 * (k % 4) + 8 * ((k / 4) % 4) + k / 16;
      if (capData[idx % 16][k] != expAll[idx % 16][slot]) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    check(bad == 0, "R6 natural order words wrong", bad, 0);
  endtask

  task automatic tReset();
    check(chanValid == 1'b0, "R1 chanValid after reset", int'(chanValid), 0);
    check(frameErr == 1'b0, "R1 frameErr after reset", int'(frameErr), 0);
  endtask

  task automatic tIdleTicks();
    int f0 = frameCount;
    int e0 = errPulses;
    for (int t = 0; t < 3; t++) begin
      putValue(hiLvl(), hiLvl());
      idleLow(68);
    end
    waitCycles(20);
    check(frameCount == f0, "R2 idle ticks made frames", frameCount - f0, 0);
    check(errPulses == e0, "R2 idle ticks made errors", errPulses - e0, 0);
  endtask

  task automatic tBasic();
    int f0 = frameCount;
    sendFrame(2'b10, 8'hA5, 3, 1'b0, -1, 8);
    waitCycles(300);
    check(frameCount == f0 + 1, "R7 frame count", frameCount - f0, 1);
    checkFrame(f0, 4'b1110, 8'hA5);
    check(flagBad == 0, "R7 first/last/contiguity", flagBad, 0);
  endtask

  task automatic tSecondLow();
    int f0 = frameCount;
    int e0 = errPulses;
    putValue(hiLvl(), hiLvl());
    putValue(loLvl(), loLvl());
    idleLow(300);
    waitCycles(200);
    check(frameCount == f0, "R3 second header level low started frame", frameCount - f0, 0);
    check(errPulses == e0, "R3 rejected start raised error", errPulses - e0, 0);
  endtask

  task automatic tPolarity();
    int f0 = frameCount;
    invertPol = 1'b1;
    idleLow(4);
    sendFrame(2'b01, 8'h3C, 11, 1'b0, -1, 8);
    waitCycles(300);
    check(frameCount == f0 + 1, "R8 inverted polarity frame count", frameCount - f0, 1);
    checkFrame(f0, 4'b1101, 8'h3C);
    invertPol = 1'b0;
    idleLow(4);
  endtask

  task automatic tThreshEqual();
    int f0 = frameCount;
    for (int i = 0; i < 10; i++) putSample(SW'(THR), 1'b1);
    idleLow(4);
    waitCycles(20);
    check(frameCount == f0, "R11 raw sample at threshold started frame", frameCount - f0, 0);
    sendFrame(2'b11, 8'h81, 23, 1'b1, -1, 8);
    waitCycles(300);
    check(frameCount == f0 + 1, "R11 frame count", frameCount - f0, 1);
    check(capHdr[f0 % 16] == 4'b1110, "R11 level at threshold reads low",
          int'(capHdr[f0 % 16]), 14);
  endtask

  task automatic tTruncate();
    int f0 = frameCount;
    int e0 = errPulses;
    sendFrame(2'b11, 8'h55, 5, 1'b0, 50, 0);
    waitCycles(300);
    check(errPulses == e0 + 1, "R9 frameErr pulses", errPulses - e0, 1);
    check(frameCount == f0, "R9 partial frame produced output", frameCount - f0, 0);
    sendFrame(2'b00, 8'h0F, 7, 1'b0, -1, 8);
    waitCycles(300);
    check(frameCount == f0 + 1, "R9 frame after truncation", frameCount - f0, 1);
    checkFrame(f0, 4'b1100, 8'h0F);
  endtask

  task automatic tBackToBack();
    int f0 = frameCount;
    sendFrame(2'b01, 8'h11, 41, 1'b0, -1, 0);
    sendFrame(2'b10, 8'h22, 42, 1'b0, -1, 0);
    sendFrame(2'b11, 8'h33, 43, 1'b0, -1, 4);
    waitCycles(400);
    check(frameCount == f0 + 3, "R10 back-to-back frame count", frameCount - f0, 3);
    checkFrame(f0,     4'b1101, 8'h11);
    checkFrame(f0 + 1, 4'b1110, 8'h22);
    checkFrame(f0 + 2, 4'b1111, 8'h33);
    check(flagBad == 0, "R7 R10 flags across banks", flagBad, 0);
  endtask

  initial begin
    waitCycles(5);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    idleLow(4);
    tIdleTicks();
    tBasic();
    tSecondLow();
    tPolarity();
    tThreshEqual();
    tTruncate();
    tBackToBack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule